// File: doc/BRIEF.md
# Descriptor condition evaluator

This block decides, for one channel of a descriptor-driven DMA engine, whether the interrupt, branch and wait actions of the descriptor now being executed take effect. Each action has a 2-bit mode field in the descriptor: never, always, act when a condition holds, or act when it does not. Each action has its own select register. The register holds a 4-bit mask and a 4-bit compare value. The condition for an action is true when the masked device-status bits equal the masked compare value.

The sequencer that owns the channel presents the descriptor's control field and raises an evaluation strobe for one cycle. One clock later the block returns a one-cycle result: an interrupt pulse, a take-branch flag and a stall flag. A raised interrupt also sets a sticky interrupt line, which stays high until software clears it. The three select registers are loaded and read back through a simple word-wide write and read port. Descriptor fetch, data movement and channel control sit outside this block.

Top module: `dsc_cond_eval`

## Requirements
- R1: After reset all three select registers read zero, and result_valid_o, irq_pulse_o, irq_o, take_branch_o and stall_o are all low.
- R2: A write to address 0 loads the interrupt select register, address 1 the branch select register and address 2 the wait select register. Only bits 19:16 (mask) and 3:0 (compare value) are kept. All other bits read back as zero. Writes to address 3 have no effect, and reads of address 3 return zero. rd_data_o is combinational on rd_addr_i. A select register keeps its value while it is not written.
- R3: The condition for an action is ((dev_status_i[3:0] & mask) == (value & mask)). Bits 7:4 of dev_status_i never change any result. A zero mask makes the condition true.
- R4: Each 2-bit mode field is decoded as 00 = never, 01 = act if the condition is true, 10 = act if the condition is false, 11 = always. The interrupt mode is desc_ctrl_i[5:4], the branch mode is desc_ctrl_i[3:2] and the wait mode is desc_ctrl_i[1:0]. In mode 00 the output stays low, and in mode 11 it goes high, whatever the status.
- R5: The interrupt, branch and wait conditions each use only their own select register.
- R6: The results for a descriptor appear on the clock edge that samples desc_valid_i high, and are held for exactly one cycle with result_valid_o high. In every other cycle result_valid_o, irq_pulse_o, take_branch_o and stall_o are low.
- R7: irq_o rises together with irq_pulse_o and stays high until a cycle with irq_clr_i high and no new interrupt. A new interrupt in the same cycle as irq_clr_i keeps irq_o high.
- R8: When a select-register write and an evaluation fall in the same cycle, the evaluation uses the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Select-register write strobe |
| wr_addr_i | input | 2 | Write address: 0 interrupt, 1 branch, 2 wait |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 32 | Read data of the addressed select register |
| dev_status_i | input | 8 | Device-status field; the low 4 bits are compared |
| desc_valid_i | input | 1 | Evaluate the current descriptor this cycle |
| desc_ctrl_i | input | 6 | Interrupt, branch and wait mode fields |
| irq_clr_i | input | 1 | Software clear of the sticky interrupt |
| result_valid_o | output | 1 | Results below are valid this cycle |
| irq_pulse_o | output | 1 | One-cycle interrupt event |
| irq_o | output | 1 | Sticky interrupt line |
| take_branch_o | output | 1 | Take the descriptor branch |
| stall_o | output | 1 | Stall the channel before completion |

## Verification
The three action results and the sticky interrupt line are due one clock edge after the cycle that presents desc_valid_i. Read data changes at the write edge itself, since it is combinational from the registers. The bench drives every input just after a falling edge. Its reference model advances at the following rising edge, using the inputs and the register image from before that edge. The bench then compares every output at the next falling edge, so each comparison sees exactly one edge of latency. Same-cycle write and evaluate, simultaneous set and clear of the interrupt, and changes to the upper status bits are all exercised through this same per-cycle comparison.

// File: rtl/dce_pkg.sv
`timescale 1ns/1ps
package dce_pkg;
  typedef enum logic [1:0] {
    CM_NEVER    = 2'b00,
    CM_IF_TRUE  = 2'b01,
    CM_IF_FALSE = 2'b10,
    CM_ALWAYS   = 2'b11
  } cond_mode_e;

  localparam int NUM_KINDS = 3;
  localparam int K_INTR    = 0;
  localparam int K_BRANCH  = 1;
  localparam int K_WAIT    = 2;
  localparam int MODE_W    = 2;
endpackage

// File: rtl/dce_sel_reg.sv
`timescale 1ns/1ps
module dce_sel_reg #(
  parameter int DATA_W   = 32,
  parameter int COND_W   = 4,
  parameter int MASK_LSB = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [COND_W-1:0] mask_o,
  output logic [COND_W-1:0] cmp_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] FIELD_ONES = DATA_W'((1 << COND_W) - 1);
  localparam logic [DATA_W-1:0] KEEP_MASK  = FIELD_ONES | (FIELD_ONES << MASK_LSB);

  logic [DATA_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= wdata_i & KEEP_MASK;
  end

  assign mask_o  = q[MASK_LSB +: COND_W];
  assign cmp_o   = q[COND_W-1:0];
  assign rdata_o = q;

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o)); // R2
endmodule

// File: rtl/dce_cond_unit.sv
`timescale 1ns/1ps
module dce_cond_unit
  import dce_pkg::*;
#(
  parameter int DEV_W  = 8,
  parameter int COND_W = 4
) (
  input  logic [DEV_W-1:0]  status_i,
  input  logic [COND_W-1:0] mask_i,
  input  logic [COND_W-1:0] cmp_i,
  input  cond_mode_e        mode_i,
  output logic              act_o
);
  localparam int PAD_W = DEV_W - COND_W;

  logic [DEV_W-1:0] mask_ext, cmp_ext;
  logic             cond;

  // upper status bits meet a zero mask, so they never take part
  assign mask_ext = {{PAD_W{1'b0}}, mask_i};
  assign cmp_ext  = {{PAD_W{1'b0}}, cmp_i};
  assign cond     = (status_i & mask_ext) == (cmp_ext & mask_ext);

  always_comb begin
    unique case (mode_i)
      CM_NEVER:    act_o = 1'b0;
      CM_IF_TRUE:  act_o = cond;
      CM_IF_FALSE: act_o = !cond;
      CM_ALWAYS:   act_o = 1'b1;
      default:     act_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dsc_cond_eval.sv
`timescale 1ns/1ps
module dsc_cond_eval
  import dce_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int DEV_W    = 8,
  parameter int COND_W   = 4,
  parameter int MASK_LSB = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [DEV_W-1:0]  dev_status_i,
  input  logic              desc_valid_i,
  input  logic [5:0]        desc_ctrl_i,
  input  logic              irq_clr_i,
  output logic              result_valid_o,
  output logic              irq_pulse_o,
  output logic              irq_o,
  output logic              take_branch_o,
  output logic              stall_o
);
  localparam int CTRL_W = NUM_KINDS * MODE_W;

  logic [NUM_KINDS-1:0] fire;
  logic [NUM_KINDS-1:0] act_q;
  logic [DATA_W-1:0]    rdata [NUM_KINDS];
  logic                 valid_q, irq_q;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    localparam int LSB = (NUM_KINDS - 1 - k) * MODE_W;
    logic [COND_W-1:0] mask, cmp;
    logic              we;

    assign we = wr_en_i && (wr_addr_i == 2'(k));

    dce_sel_reg #(.DATA_W(DATA_W), .COND_W(COND_W), .MASK_LSB(MASK_LSB)) u_sel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we),
      .wdata_i(wr_data_i),
      .mask_o (mask),
      .cmp_o  (cmp),
      .rdata_o(rdata[k])
    );

    dce_cond_unit #(.DEV_W(DEV_W), .COND_W(COND_W)) u_cond (
      .status_i(dev_status_i),
      .mask_i  (mask),
      .cmp_i   (cmp),
      .mode_i  (cond_mode_e'(desc_ctrl_i[LSB +: MODE_W])),
      .act_o   (fire[k])
    );
  end

  always_comb begin
    rd_data_o = '0;
    if (32'(rd_addr_i) < NUM_KINDS) rd_data_o = rdata[rd_addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      act_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      valid_q <= desc_valid_i;
      act_q   <= desc_valid_i ? fire : '0;
      // a new event wins over a clear in the same cycle
      if (desc_valid_i && fire[K_INTR]) irq_q <= 1'b1;
      else if (irq_clr_i)               irq_q <= 1'b0;
    end
  end

  assign result_valid_o = valid_q;
  assign irq_pulse_o    = act_q[K_INTR];
  assign take_branch_o  = act_q[K_BRANCH];
  assign stall_o        = act_q[K_WAIT];
  assign irq_o          = irq_q;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !desc_valid_i |=> !(result_valid_o || irq_pulse_o || take_branch_o || stall_o)); // R6
  AST_NEVER_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i && desc_ctrl_i[3:2] == 2'b00 |=> !take_branch_o); // R4
  AST_ALWAYS_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i && desc_ctrl_i[1:0] == 2'b11 |=> stall_o); // R4
  AST_IRQ_WITH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pulse_o |-> irq_o); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o); // R7
endmodule

// File: tb/dsc_cond_eval_test.sv
`timescale 1ns/1ps
module dsc_cond_eval_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0]  dev_status = '0;
  logic        desc_valid = 1'b0;
  logic [5:0]  desc_ctrl = '0;
  logic        irq_clr = 1'b0;
  logic        res_valid, irq_pulse, irq, take_br, stall;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  int m_mask [3];
  int m_cmp  [3];
  bit m_valid, m_act0, m_act1, m_act2, m_irq;

  always #4 clk = ~clk;

  dsc_cond_eval uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .dev_status_i(dev_status), .desc_valid_i(desc_valid), .desc_ctrl_i(desc_ctrl),
    .irq_clr_i(irq_clr),
    .result_valid_o(res_valid), .irq_pulse_o(irq_pulse), .irq_o(irq),
    .take_branch_o(take_br), .stall_o(stall)
  );

  function automatic bit model_fire(int mode, int kind, int st);
    bit c;
    c = ((st & m_mask[kind]) == (m_cmp[kind] & m_mask[kind]));
    case (mode)
      0: return 1'b0;
      1: return c;
      2: return !c;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(string tag, string name, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    int exp_rd;
    exp_rd = (rd_addr < 3) ? ((m_mask[rd_addr] << 16) | m_cmp[rd_addr]) : 0;
    check(tag, "result_valid", int'(res_valid), int'(m_valid));
    check(tag, "irq_pulse",    int'(irq_pulse), int'(m_act0));
    check(tag, "take_branch",  int'(take_br),   int'(m_act1));
    check(tag, "stall",        int'(stall),     int'(m_act2));
    check(tag, "irq",          int'(irq),       int'(m_irq));
    check(tag, "rd_data",      int'(rd_data),   exp_rd);
  endtask

  // called just after a falling edge; drives, advances one rising edge, compares
  task automatic step(string tag, bit v, logic [5:0] ctrl, logic [7:0] st,
                      bit we, logic [1:0] wa, logic [31:0] wd, bit clr, logic [1:0] ra);
    bit f0, f1, f2;
    desc_valid = v; desc_ctrl = ctrl; dev_status = st;
    wr_en = we; wr_addr = wa; wr_data = wd; irq_clr = clr; rd_addr = ra;
    @(posedge clk);
    f0 = model_fire(int'(ctrl[5:4]), 0, int'(st[3:0]));
    f1 = model_fire(int'(ctrl[3:2]), 1, int'(st[3:0]));
    f2 = model_fire(int'(ctrl[1:0]), 2, int'(st[3:0]));
    m_valid = v;
    m_act0 = v && f0; m_act1 = v && f1; m_act2 = v && f2;
    if (v && f0) m_irq = 1'b1;
    else if (clr) m_irq = 1'b0;
    if (we && wa < 3) begin
      m_mask[wa] = int'((wd >> 16) & 32'hF);
      m_cmp[wa]  = int'(wd & 32'hF);
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic wr(string tag, logic [1:0] a, logic [31:0] d);
    step(tag, 0, '0, '0, 1, a, d, 0, a);
  endtask

  task automatic idle(string tag, logic [1:0] ra);
    step(tag, 0, '0, '0, 0, '0, '0, 0, ra);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    for (int k = 0; k < 3; k++) begin m_mask[k] = 0; m_cmp[k] = 0; end
    m_valid = 0; m_act0 = 0; m_act1 = 0; m_act2 = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) idle("R1", 2'(a));

    // R2: field retention, reserved bits, unmapped address
    wr("R2", 2'd0, 32'hFFFF_FFFF);
    wr("R2", 2'd3, 32'hFFFF_FFFF);
    idle("R2", 2'd3);
    idle("R2", 2'd0);
    wr("R2", 2'd1, 32'h1234_5678);
    idle("R2", 2'd1);
    idle("R2", 2'd2);

    // program distinct selects: intr mask F val 5, branch mask 3 val 2, wait mask 8 val 8
    wr("R2", 2'd0, 32'h000F_0005);
    wr("R2", 2'd1, 32'h0003_0002);
    wr("R2", 2'd2, 32'h0008_0008);

    // R4/R5: every control pattern against several statuses
    for (int s = 0; s < 16; s += 3)
      for (int c = 0; c < 64; c++) begin
        step("R4", 1, 6'(c), 8'(s), 0, '0, '0, (c % 7) == 0, 2'(c % 4));
        if ((c % 5) == 0) idle("R6", 2'(c % 4));
      end

    // R5: status 0x5 matches interrupt select only
    step("R5", 1, 6'b01_01_01, 8'h05, 0, '0, '0, 0, 2'd0);
    step("R5", 1, 6'b01_01_01, 8'h0A, 0, '0, '0, 0, 2'd1);
    step("R5", 1, 6'b10_10_10, 8'h0E, 0, '0, '0, 1, 2'd2);

    // R3: upper status bits have no effect; zero mask always matches
    for (int u = 0; u < 16; u++)
      step("R3", 1, 6'b01_01_10, {4'(u), 4'h5}, 0, '0, '0, 1, 2'd0);
    wr("R3", 2'd1, 32'h0000_0009);
    for (int s = 0; s < 16; s += 5)
      step("R3", 1, 6'b00_01_00, 8'(s), 0, '0, '0, 0, 2'd1);

    // R6: back-to-back evaluations, then idle
    step("R6", 1, 6'b11_11_11, 8'h00, 0, '0, '0, 0, 2'd0);
    step("R6", 1, 6'b00_00_00, 8'h00, 0, '0, '0, 0, 2'd0);
    step("R6", 0, 6'b11_11_11, 8'h00, 0, '0, '0, 0, 2'd0);

    // R7: sticky line, clear, set wins over clear
    step("R7", 1, 6'b11_00_00, 8'h00, 0, '0, '0, 1, 2'd0);
    idle("R7", 2'd0);
    idle("R7", 2'd0);
    step("R7", 0, '0, '0, 0, '0, '0, 1, 2'd0);
    idle("R7", 2'd0);
    step("R7", 1, 6'b11_00_00, 8'h00, 0, '0, '0, 0, 2'd0);
    step("R7", 1, 6'b11_00_00, 8'h00, 0, '0, '0, 1, 2'd0);
    step("R7", 1, 6'b00_11_00, 8'h00, 0, '0, '0, 1, 2'd0);

    // R8: write and evaluate in the same cycle use the old contents
    wr("R8", 2'd0, 32'h000F_0003);
    step("R8", 1, 6'b01_00_00, 8'h03, 1, 2'd0, 32'h000F_000C, 0, 2'd0);
    step("R8", 1, 6'b01_00_00, 8'h03, 0, '0, '0, 1, 2'd0);
    step("R8", 1, 6'b01_00_00, 8'h0C, 1, 2'd2, 32'h0001_0000, 0, 2'd2);
    step("R8", 1, 6'b00_00_01, 8'h01, 0, '0, '0, 0, 2'd2);
    idle("R8", 2'd2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule